// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a 32-bit count of elapsed seconds behind a small register bus with APB-style two-phase accesses. A prescaler divides the system clock by a parameter, `TICK_DIV`, to produce a one-cycle tick once per second. Each tick advances the count, and software may overwrite the count at any time through a load register.

Software also programs a 32-bit alarm value. Each time the count takes a new value, whether from a tick or a load, the block compares it with the alarm value. A fresh write of the alarm value is compared in the same way. On a hit, the block sets a sticky pending bit. A mask bit gates the pending bit onto a level interrupt line. A write to the acknowledge register drops the pending bit again.

A fixed block of eight identification bytes sits at the top of the 4 KB register window. Every access completes in a single access phase, with no wait states.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the count (0x00), alarm (0x04), load readback (0x08), mask (0x10), pending (0x14) and masked pending (0x18) all read 0, and `irq` is low.
- R2: The count rises by one on each tick, and ticks arrive every `TICK_DIV` clock cycles. After 0xFFFFFFFF the count continues at 0.
- R3: A write to 0x08 puts the written value into the count on that access edge and restarts the prescaler phase, so the next increment comes `TICK_DIV` cycles later. A read of 0x08 returns the last value written there.
- R4: The pending bit (bit 0 of 0x14) sets on the tick that makes the count equal to the alarm value. This also works for an alarm value below the current count, which fires after the count wraps. The bit stays set while the count moves past the alarm value, and it never sets without a tick or a write to 0x04 or 0x08.
- R5: The pending bit sets on the access edge of a write to 0x04 or 0x08 that leaves the count equal to the alarm value.
- R6: Bit 0 of 0x10 holds the mask, and only bit 0 of the written data is kept. `irq` and bit 0 of 0x18 both equal pending AND mask.
- R7: Any write to 0x1C clears the pending bit, whatever the data value. The bit stays clear even if the count still equals the alarm value. A set event in the same cycle takes priority.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: Word reads of 0xFE0 through 0xFFC return these identification bytes in order: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: The following read as 0: offset 0x1C, any unmapped offset, and any offset whose two low bits are nonzero. Writes to 0x00, 0x14 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq | output | 1 | Level interrupt, pending AND mask |

## Verification
The bench first loads values close to a tick and reads the count just before and just after the predicted edge. A prescaler that does not restart on a load, or that is off by one in its period, then returns a count one away from the expected value. It programs an alarm value below the current count and waits across the 0xFFFFFFFF wrap. A magnitude compare would fire at once, and a count with the wrong width would never fire. It writes the alarm value equal to the current count, and separately loads the count to equal the alarm value, so a design that only compares on ticks misses the alarm. It clears the pending bit while the count still equals the alarm value, so a design that holds the compare as a level re-asserts the bit at once. It also writes 1s into the read-only status offsets, so a decode that lets those writes through shows a spurious pending bit.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CNT_W  = 32;
    localparam int ADDR_W = 12;
    localparam int WORD_W = ADDR_W - 2;

    // word indices (byte offset >> 2)
    localparam logic [WORD_W-1:0] W_COUNT = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_ALARM = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_LOAD  = WORD_W'(2);
    localparam logic [WORD_W-1:0] W_CTRL  = WORD_W'(3);
    localparam logic [WORD_W-1:0] W_MASK  = WORD_W'(4);
    localparam logic [WORD_W-1:0] W_PEND  = WORD_W'(5);
    localparam logic [WORD_W-1:0] W_MPEND = WORD_W'(6);
    localparam logic [WORD_W-1:0] W_ACK   = WORD_W'(7);

    typedef struct packed {
        logic load;
        logic alarm;
        logic mask;
        logic ack;
    } rtc_wr_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alarm;
        logic [CNT_W-1:0] load;
        logic             mask;
        logic             pend;
    } rtc_state_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] ph_d, ph_q;

    always_comb begin
        tick = (ph_q == LAST);
        ph_d = ph_q + W'(1);
        if (restart || tick) begin
            ph_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/rtc_decode.sv
module rtc_decode
    import rtc_pkg::*;
(
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output rtc_wr_t           wr
);
    logic              wr_go;
    logic [WORD_W-1:0] word;

    always_comb begin
        word  = paddr[ADDR_W-1:2];
        wr_go = psel && penable && pwrite && (paddr[1:0] == 2'b00);
        wr       = '0;
        wr.load  = wr_go && (word == W_LOAD);
        wr.alarm = wr_go && (word == W_ALARM);
        wr.mask  = wr_go && (word == W_MASK);
        wr.ack   = wr_go && (word == W_ACK);
    end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  rtc_wr_t          wr,
    input  logic [CNT_W-1:0] wdata,
    output rtc_state_t       st_q
);
    rtc_state_t st_d;
    logic       event_d;
    logic       hit_d;

    always_comb begin
        st_d = st_q;
        if (wr.load) begin
            st_d.cnt  = wdata;
            st_d.load = wdata;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (wr.alarm) begin
            st_d.alarm = wdata;
        end
        if (wr.mask) begin
            st_d.mask = wdata[0];
        end
        // compare only when count or alarm value is freshly written
        event_d = tick || wr.load || wr.alarm;
        hit_d   = event_d && (st_d.cnt == st_d.alarm);
        if (hit_d) begin
            st_d.pend = 1'b1;
        end else if (wr.ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr.load) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr.load |=> (st_q.cnt == $past(wdata)));

    // R4
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !wr.ack) |=> st_q.pend);

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && !tick && !wr.load && !wr.alarm) |=> !st_q.pend);

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.ack && !tick) |=> !st_q.pend);

endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_pkg::*;
#(
    parameter int TICK_DIV = 125_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        irq
);
    rtc_wr_t           wr;
    rtc_state_t        st;
    logic              tick;
    logic [WORD_W-1:0] word;

    rtc_decode u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr      (wr)
    );

    rtc_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr.load),
        .tick    (tick)
    );

    rtc_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (wr),
        .wdata (pwdata),
        .st_q  (st)
    );

    always_comb begin
        word   = paddr[ADDR_W-1:2];
        prdata = '0;
        if (paddr[1:0] == 2'b00) begin
            if (word[WORD_W-1:3] == '1) begin
                prdata = {24'd0, id_byte(word[2:0])};
            end else begin
                case (word)
                    W_COUNT: prdata = st.cnt;
                    W_ALARM: prdata = st.alarm;
                    W_LOAD:  prdata = st.load;
                    W_CTRL:  prdata = 32'd1;
                    W_MASK:  prdata = {31'd0, st.mask};
                    W_PEND:  prdata = {31'd0, st.pend};
                    W_MPEND: prdata = {31'd0, st.pend & st.mask};
                    default: prdata = '0;
                endcase
            end
        end
        irq = st.pend & st.mask;
    end

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.mask && !pwdata[0]) |=> !irq);

endmodule

// File: tb/rtc_sec_alarm_tb.sv
module rtc_sec_alarm_tb;
    localparam int DIV = 20;

    localparam logic [11:0] A_COUNT = 12'h000;
    localparam logic [11:0] A_ALARM = 12'h004;
    localparam logic [11:0] A_LOAD  = 12'h008;
    localparam logic [11:0] A_CTRL  = 12'h00C;
    localparam logic [11:0] A_MASK  = 12'h010;
    localparam logic [11:0] A_PEND  = 12'h014;
    localparam logic [11:0] A_MPEND = 12'h018;
    localparam logic [11:0] A_ACK   = 12'h01C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    rtc_sec_alarm #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = we; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        access(1'b1, a, d);
    endtask

    // driver: push expectation, then perform the read
    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, a, 32'd0);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // count seen by a read issued after idle(k) following a load of l
    function automatic logic [31:0] cnt_after(input logic [31:0] l, input int k);
        return l + 32'((k + 2) / DIV);
    endfunction

    // monitor: compare read data in each read access phase
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (psel && penable && !pwrite) begin
                if (exp_q.size() == 0) begin
                    check(prdata, 32'hDEADBEEF, "monitor-unexpected-read");
                end else begin
                    check(prdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state (count first, before the first tick)
        rd(A_COUNT, 32'd0, "R1 count");
        rd(A_ALARM, 32'd0, "R1 alarm");
        rd(A_LOAD,  32'd0, "R1 load");
        rd(A_MASK,  32'd0, "R1 mask");
        rd(A_PEND,  32'd0, "R1 pend");
        rd(A_MPEND, 32'd0, "R1 masked");
        check({31'd0, irq}, 32'd0, "R1 irq");

        // R9 identification bytes
        rd(12'hFE0, 32'h31, "R9 id0");
        rd(12'hFE4, 32'h10, "R9 id1");
        rd(12'hFE8, 32'h14, "R9 id2");
        rd(12'hFEC, 32'h00, "R9 id3");
        rd(12'hFF0, 32'h0D, "R9 id4");
        rd(12'hFF4, 32'hF0, "R9 id5");
        rd(12'hFF8, 32'h05, "R9 id6");
        rd(12'hFFC, 32'hB1, "R9 id7");

        // R8 control
        rd(A_CTRL, 32'd1, "R8 ctrl");
        wr(A_CTRL, 32'd0);
        rd(A_CTRL, 32'd1, "R8 ctrl after write");

        // R10 unmapped, misaligned, ack reads
        rd(A_ACK,  32'd0, "R10 ack read");
        rd(12'h020, 32'd0, "R10 unmapped 0x020");
        rd(12'h800, 32'd0, "R10 unmapped 0x800");
        rd(12'h002, 32'd0, "R10 misaligned");

        // R3 / R2 load and tick timing
        wr(A_LOAD, 32'd100); idle(15);
        rd(A_COUNT, cnt_after(32'd100, 15), "R3 before first tick");
        wr(A_LOAD, 32'd100); idle(18);
        rd(A_COUNT, cnt_after(32'd100, 18), "R2 first tick");
        wr(A_LOAD, 32'd100); idle(57);
        rd(A_COUNT, cnt_after(32'd100, 57), "R2 two ticks");
        rd(A_LOAD, 32'd100, "R3 load readback");
        wr(A_LOAD, 32'hFFFF_FFFF); idle(18);
        rd(A_COUNT, 32'd0, "R2 wrap to zero");

        // R4 tick match, sticky
        wr(A_ALARM, 32'h50);
        wr(A_LOAD, 32'h4F);
        wr(A_ACK, 32'd0);
        idle(5);
        rd(A_PEND, 32'd0, "R4 not before match");
        idle(20);
        rd(A_PEND, 32'd1, "R4 set on match tick");
        idle(40);
        rd(A_PEND, 32'd1, "R4 sticky past match");

        // R6 mask
        rd(A_MPEND, 32'd0, "R6 masked off");
        check({31'd0, irq}, 32'd0, "R6 irq masked");
        wr(A_MASK, 32'hFFFF_FFFE);
        rd(A_MASK, 32'd0, "R6 only bit0 kept");
        wr(A_MASK, 32'd3);
        rd(A_MASK, 32'd1, "R6 mask bit0");
        rd(A_MPEND, 32'd1, "R6 masked pending");
        check({31'd0, irq}, 32'd1, "R6 irq high");

        // R7 clear with zero data
        wr(A_ACK, 32'd0);
        check({31'd0, irq}, 32'd0, "R7 irq after ack");
        rd(A_PEND, 32'd0, "R7 pend after ack");

        // R4 wrap-safe alarm below count
        wr(A_LOAD, 32'hFFFF_FFFE);
        wr(A_ALARM, 32'd1);
        wr(A_ACK, 32'd0);
        idle(3);
        rd(A_PEND, 32'd0, "R4 alarm below count not early");
        idle(60);
        rd(A_PEND, 32'd1, "R4 alarm after wrap");
        rd(A_COUNT, 32'd1, "R2 count after wrap");
        wr(A_ACK, 32'd0);

        // R5 immediate match on alarm write and on load write
        wr(A_LOAD, 32'h777);
        wr(A_ALARM, 32'h777);
        rd(A_PEND, 32'd1, "R5 alarm write equal");
        wr(A_ACK, 32'h1234);
        rd(A_PEND, 32'd0, "R7 stays clear while equal");
        wr(A_ALARM, 32'h900);
        wr(A_LOAD, 32'h900);
        rd(A_PEND, 32'd1, "R5 load write equal");
        wr(A_ACK, 32'd0);

        // R10 writes to read-only offsets
        wr(A_LOAD, 32'h40);
        wr(A_COUNT, 32'h99);
        rd(A_COUNT, 32'h40, "R10 count write ignored");
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, 32'd0, "R10 pend write ignored");
        wr(A_MPEND, 32'hFFFF_FFFF);
        rd(A_MPEND, 32'd0, "R10 masked write ignored");

        idle(4);
        check(32'(exp_q.size()), 32'd0, "scoreboard drained");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule